// File: doc/BRIEF.md
# Cache Line Zeroing Engine

This engine sits beside the tag and data arrays of a small set-associative data cache. It carries out a single operation: clear one whole cache line, both in main memory and in the cache. A request gives a byte address, a zero-line flag and a load flag. It also carries the outcome of the tag lookup, which is a hit flag and the hit way, and the way the replacement policy would evict.

After it accepts a request, the engine runs the same beat-by-beat sequence the cache uses to refill a line after a load miss, but in the write direction. It issues one Wishbone write beat per data-RAM row. Every beat carries all-zero data with every byte lane enabled. When a beat is acknowledged, the matching row of the cache data RAM is overwritten with zeros in the same cycle.

On a hit, the line is zeroed in place in the hit way. On a miss, the replacement way is taken over. Its valid bit is cleared and its tag rewritten when the operation starts, and it becomes valid again once the last beat completes. Memory read data is never consulted, and nothing is forwarded to the load-result path.

Top module: `cline_zero`

## Requirements
- R1: A request is accepted only in a cycle where the engine is idle (`busy` low), `req_valid` and `req_zero` are high and `req_load` is low. `busy` is low after reset and rises in the cycle after acceptance. It stays high through the cycle in which `done` is high, and is low in the cycle after that.
- R2: While a beat is outstanding, `wb_cyc`, `wb_stb` and `wb_we` are high, `wb_sel` is all ones and `wb_dat_o` is zero. When no beat is outstanding, `wb_cyc`, `wb_stb`, `wb_we`, `wb_sel` and `wb_adr` are all zero.
- R3: The first beat's address is the line base of `req_addr` plus 8 times the row held in `req_addr[5:3]`. Each acknowledge advances the row by one, wrapping modulo 8 within the line. `wb_adr[2:0]` is always zero.
- R4: Each operation takes exactly 8 acknowledged beats with the default line of 64 bytes and bus of 8 bytes. In the cycle after the last acknowledge, `wb_cyc` and `wb_stb` are low and `done` is high for exactly one cycle. The engine is idle in the following cycle.
- R5: In each cycle where a beat is outstanding and `wb_ack` is high, `ram_we` is high in that same cycle. In that cycle `ram_row` is the beat's row, `ram_set` is `req_addr[9:6]` of the request, `ram_be` is all ones and `ram_wdata` is zero. `ram_we` is low in every other cycle.
- R6: On a hit (`req_hit` high at acceptance), `ram_way` equals `req_hit_way`, and there is no tag write and no valid-bit write at acceptance.
- R7: On a miss, in the acceptance cycle, `tag_we` is high with `tag_set` equal to `req_addr[9:6]`, `tag_way` equal to `repl_way` and `tag_wdata` equal to `req_addr[31:10]`. In the same cycle `vld_we` is high with `vld_wdata` low for that set and way. `ram_way` then equals `repl_way` for every beat.
- R8: In the `done` cycle, `vld_we` is high with `vld_wdata` high, for the operation's set and way.
- R9: A request with `req_load` high, or with `req_zero` low, is ignored: `busy` stays low and no bus, tag or valid activity follows.
- R10: `wb_ack` has no effect while no beat is outstanding (idle or `done` cycle): no RAM write and no change of state.
- R11: A request presented while the engine is busy is ignored and does not alter the address, set or way of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_zero | input | 1 | Request is a line-zero operation |
| req_load | input | 1 | Request is a load (mutually exclusive with zero) |
| req_addr | input | ADDR_W | Byte address inside the target line |
| req_hit | input | 1 | Tag lookup hit for the request |
| req_hit_way | input | WAY_W | Way that hit |
| repl_way | input | WAY_W | Victim way chosen by the replacement policy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | ADDR_W | Wishbone byte address, 8-byte aligned |
| wb_sel | output | BUS_BYTES | Wishbone byte selects |
| wb_dat_o | output | 8*BUS_BYTES | Wishbone write data |
| wb_ack | input | 1 | Wishbone acknowledge |
| ram_we | output | 1 | Data RAM write enable |
| ram_set | output | SET_W | Data RAM set index |
| ram_way | output | WAY_W | Data RAM way |
| ram_row | output | ROW_W | Data RAM row within the line |
| ram_be | output | BUS_BYTES | Data RAM byte enables |
| ram_wdata | output | 8*BUS_BYTES | Data RAM write data |
| tag_we | output | 1 | Tag array write enable |
| tag_set | output | SET_W | Tag array set |
| tag_way | output | WAY_W | Tag array way |
| tag_wdata | output | TAG_W | New tag |
| vld_we | output | 1 | Valid-bit write enable |
| vld_set | output | SET_W | Valid-bit set |
| vld_way | output | WAY_W | Valid-bit way |
| vld_wdata | output | 1 | Valid-bit value |

## Verification
Several properties are checked on every cycle:
- the shape of every bus beat, with full byte selects, zero data and an aligned address;
- the RAM write coinciding with an acknowledge and carrying the acknowledged row;
- the row step of one per acknowledge within a fixed line;
- the eight-beat count before `done`, and the single-cycle `done` pulse with its valid-set write;
- the miss allocation happening only from idle.

Other behaviours depend on what the request carried, and only the bench's scenarios can show them. These are the choice between the hit way and the victim way, the exact starting row and the wrap across the line end, the tag value written, and the fact that load-flagged requests, non-zero requests, requests made while busy and stray acknowledges all change nothing.

// File: rtl/zl_pkg.sv
// Shared types for the cache line zeroing engine.
// Assumes nothing beyond a single clock domain.
package zl_pkg;
    // Sequencer states: idle, waiting for beat acknowledges, completion pulse.
    typedef enum logic [1:0] {
        ZL_IDLE = 2'd0,
        ZL_WAIT = 2'd1,
        ZL_DONE = 2'd2
    } zl_state_e;
endpackage

// File: rtl/zl_seq.sv
// Beat sequencer: holds the line, starting row and way of the accepted
// request, steps a row counter on each acknowledge and raises the strobe
// for one outstanding write beat at a time.
// Assumes ROW_W >= 1 and that the row count is a power of two.
module zl_seq
    import zl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ROW_W  = 3,
    parameter int OFF_W  = 3,
    parameter int SET_W  = 4,
    parameter int WAY_W  = 2,
    localparam int LINE_W = ADDR_W - ROW_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] start_line,
    input  logic [ROW_W-1:0]  start_row,
    input  logic [WAY_W-1:0]  start_way,
    input  logic              wb_ack,
    output logic              busy,
    output logic              done,
    output logic              beat_go,
    output logic [SET_W-1:0]  cur_set,
    output logic [WAY_W-1:0]  cur_way,
    output logic [ROW_W-1:0]  cur_row,
    output logic              wb_stb,
    output logic [ADDR_W-1:0] wb_adr
);
    zl_state_e         state_q;
    logic [ROW_W-1:0]  row_q;
    logic [ROW_W-1:0]  cnt_q;
    logic [LINE_W-1:0] line_q;
    logic [WAY_W-1:0]  way_q;

    // Sequencing of one zeroing operation, reused from the refill pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ZL_IDLE;
            row_q   <= '0;
            cnt_q   <= '0;
            line_q  <= '0;
            way_q   <= '0;
        end else begin
            case (state_q)
                ZL_IDLE: begin
                    if (start) begin
                        state_q <= ZL_WAIT;
                        row_q   <= start_row;
                        cnt_q   <= '0;
                        line_q  <= start_line;
                        way_q   <= start_way;
                    end
                end
                ZL_WAIT: begin
                    if (wb_ack) begin
                        row_q <= row_q + 1'b1;
                        cnt_q <= cnt_q + 1'b1;
                        if (&cnt_q) begin
                            state_q <= ZL_DONE;
                        end
                    end
                end
                ZL_DONE: state_q <= ZL_IDLE;
                default: state_q <= ZL_IDLE;
            endcase
        end
    end

    // Status and bus address derived from the current state.
    always_comb begin
        busy    = (state_q != ZL_IDLE);
        done    = (state_q == ZL_DONE);
        wb_stb  = (state_q == ZL_WAIT);
        beat_go = wb_stb && wb_ack;
        cur_set = line_q[SET_W-1:0];
        cur_way = way_q;
        cur_row = row_q;
        wb_adr  = wb_stb ? {line_q, row_q, {OFF_W{1'b0}}} : '0;
    end
endmodule

// File: rtl/zl_arr_port.sv
// Array write port driver: turns sequencer events into write strobes for
// the data RAM, the tag array and the valid bits.
// Assumes allocation (from idle) and completion never coincide.
module zl_arr_port #(
    parameter int SET_W     = 4,
    parameter int WAY_W     = 2,
    parameter int ROW_W     = 3,
    parameter int TAG_W     = 22,
    parameter int BUS_BYTES = 8
) (
    input  logic                   alloc,
    input  logic [SET_W-1:0]       req_set,
    input  logic [TAG_W-1:0]       req_tag,
    input  logic [WAY_W-1:0]       repl_way,
    input  logic                   beat_go,
    input  logic                   done,
    input  logic [SET_W-1:0]       cur_set,
    input  logic [WAY_W-1:0]       cur_way,
    input  logic [ROW_W-1:0]       cur_row,
    output logic                   ram_we,
    output logic [SET_W-1:0]       ram_set,
    output logic [WAY_W-1:0]       ram_way,
    output logic [ROW_W-1:0]       ram_row,
    output logic [BUS_BYTES-1:0]   ram_be,
    output logic [8*BUS_BYTES-1:0] ram_wdata,
    output logic                   tag_we,
    output logic [SET_W-1:0]       tag_set,
    output logic [WAY_W-1:0]       tag_way,
    output logic [TAG_W-1:0]       tag_wdata,
    output logic                   vld_we,
    output logic [SET_W-1:0]       vld_set,
    output logic [WAY_W-1:0]       vld_way,
    output logic                   vld_wdata
);
    // Zero row write on every acknowledged beat.
    always_comb begin
        ram_we    = beat_go;
        ram_set   = cur_set;
        ram_way   = cur_way;
        ram_row   = cur_row;
        ram_be    = {BUS_BYTES{beat_go}};
        ram_wdata = '0;
    end

    // Tag install and valid clear on allocation, valid set on completion.
    always_comb begin
        tag_we    = alloc;
        tag_set   = req_set;
        tag_way   = repl_way;
        tag_wdata = req_tag;
        vld_we    = alloc || done;
        vld_set   = done ? cur_set : req_set;
        vld_way   = done ? cur_way : repl_way;
        vld_wdata = done;
    end
endmodule

// File: rtl/cline_zero.sv
// Cache line zeroing engine top: accepts a zero-line request from idle,
// picks the hit way or the victim way, and wires the sequencer to the
// bus and to the array write ports.
// Assumes power-of-two line, bus width, set and way counts.
module cline_zero
    import zl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BUS_BYTES  = 8,
    parameter int LINE_BYTES = 64,
    parameter int NUM_SETS   = 16,
    parameter int NUM_WAYS   = 4,
    localparam int ROWS       = LINE_BYTES / BUS_BYTES,
    localparam int ROW_W      = $clog2(ROWS),
    localparam int OFF_W      = $clog2(BUS_BYTES),
    localparam int LINE_OFF_W = ROW_W + OFF_W,
    localparam int SET_W      = $clog2(NUM_SETS),
    localparam int WAY_W      = $clog2(NUM_WAYS),
    localparam int TAG_W      = ADDR_W - LINE_OFF_W - SET_W,
    localparam int DATA_W     = 8 * BUS_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_zero,
    input  logic                 req_load,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_hit,
    input  logic [WAY_W-1:0]     req_hit_way,
    input  logic [WAY_W-1:0]     repl_way,
    output logic                 busy,
    output logic                 done,
    output logic                 wb_cyc,
    output logic                 wb_stb,
    output logic                 wb_we,
    output logic [ADDR_W-1:0]    wb_adr,
    output logic [BUS_BYTES-1:0] wb_sel,
    output logic [DATA_W-1:0]    wb_dat_o,
    input  logic                 wb_ack,
    output logic                 ram_we,
    output logic [SET_W-1:0]     ram_set,
    output logic [WAY_W-1:0]     ram_way,
    output logic [ROW_W-1:0]     ram_row,
    output logic [BUS_BYTES-1:0] ram_be,
    output logic [DATA_W-1:0]    ram_wdata,
    output logic                 tag_we,
    output logic [SET_W-1:0]     tag_set,
    output logic [WAY_W-1:0]     tag_way,
    output logic [TAG_W-1:0]     tag_wdata,
    output logic                 vld_we,
    output logic [SET_W-1:0]     vld_set,
    output logic [WAY_W-1:0]     vld_way,
    output logic                 vld_wdata
);
    logic                 accept;
    logic                 beat_go;
    logic [SET_W-1:0]     cur_set;
    logic [WAY_W-1:0]     cur_way;
    logic [ROW_W-1:0]     cur_row;
    logic [WAY_W-1:0]     start_way;
    logic                 unused_byte_off;

    // Request acceptance and way selection.
    always_comb begin
        accept          = !busy && req_valid && req_zero && !req_load;
        start_way       = req_hit ? req_hit_way : repl_way;
        unused_byte_off = ^req_addr[OFF_W-1:0];
    end

    // Fixed bus beat shape: full-width zero writes.
    always_comb begin
        wb_cyc   = wb_stb;
        wb_we    = wb_stb;
        wb_sel   = {BUS_BYTES{wb_stb}};
        wb_dat_o = '0;
    end

    zl_seq #(
        .ADDR_W(ADDR_W),
        .ROW_W (ROW_W),
        .OFF_W (OFF_W),
        .SET_W (SET_W),
        .WAY_W (WAY_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_line(req_addr[ADDR_W-1:LINE_OFF_W]),
        .start_row (req_addr[OFF_W +: ROW_W]),
        .start_way (start_way),
        .wb_ack    (wb_ack),
        .busy      (busy),
        .done      (done),
        .beat_go   (beat_go),
        .cur_set   (cur_set),
        .cur_way   (cur_way),
        .cur_row   (cur_row),
        .wb_stb    (wb_stb),
        .wb_adr    (wb_adr)
    );

    zl_arr_port #(
        .SET_W    (SET_W),
        .WAY_W    (WAY_W),
        .ROW_W    (ROW_W),
        .TAG_W    (TAG_W),
        .BUS_BYTES(BUS_BYTES)
    ) i_arr (
        .alloc    (accept && !req_hit),
        .req_set  (req_addr[LINE_OFF_W +: SET_W]),
        .req_tag  (req_addr[ADDR_W-1 -: TAG_W]),
        .repl_way (repl_way),
        .beat_go  (beat_go),
        .done     (done),
        .cur_set  (cur_set),
        .cur_way  (cur_way),
        .cur_row  (cur_row),
        .ram_we   (ram_we),
        .ram_set  (ram_set),
        .ram_way  (ram_way),
        .ram_row  (ram_row),
        .ram_be   (ram_be),
        .ram_wdata(ram_wdata),
        .tag_we   (tag_we),
        .tag_set  (tag_set),
        .tag_way  (tag_way),
        .tag_wdata(tag_wdata),
        .vld_we   (vld_we),
        .vld_set  (vld_set),
        .vld_way  (vld_way),
        .vld_wdata(vld_wdata)
    );
endmodule

// File: rtl/cline_zero_chk.sv
// Protocol checker for the cache line zeroing engine, bound to every
// instance of the top. Counts acknowledged beats to check the line length.
module cline_zero_chk #(
    parameter int ADDR_W     = 32,
    parameter int BUS_BYTES  = 8,
    parameter int LINE_BYTES = 64,
    localparam int ROWS       = LINE_BYTES / BUS_BYTES,
    localparam int ROW_W      = $clog2(ROWS),
    localparam int OFF_W      = $clog2(BUS_BYTES),
    localparam int LINE_OFF_W = ROW_W + OFF_W,
    localparam int CNT_W      = ROW_W + 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_zero,
    input logic                   req_load,
    input logic                   busy,
    input logic                   done,
    input logic                   wb_cyc,
    input logic                   wb_stb,
    input logic                   wb_we,
    input logic [ADDR_W-1:0]      wb_adr,
    input logic [BUS_BYTES-1:0]   wb_sel,
    input logic [8*BUS_BYTES-1:0] wb_dat_o,
    input logic                   wb_ack,
    input logic                   ram_we,
    input logic [ROW_W-1:0]       ram_row,
    input logic [BUS_BYTES-1:0]   ram_be,
    input logic [8*BUS_BYTES-1:0] ram_wdata,
    input logic                   tag_we,
    input logic                   vld_we,
    input logic                   vld_wdata
);
    logic [CNT_W-1:0] beats_q;

    // Acknowledged beats within the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            beats_q <= '0;
        end else if (wb_stb && wb_ack) begin
            beats_q <= beats_q + 1'b1;
        end
    end

    p_beat_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> (wb_cyc && wb_we && (&wb_sel) && (wb_dat_o == '0)));

    p_adr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_adr[OFF_W-1:0] == '0);

    p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && wb_ack) |=> (!wb_stb ||
            (wb_adr[OFF_W +: ROW_W] == ROW_W'($past(wb_adr[OFF_W +: ROW_W]) + 1'b1))));

    p_line_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && $past(wb_stb)) |->
            (wb_adr[ADDR_W-1:LINE_OFF_W] == $past(wb_adr[ADDR_W-1:LINE_OFF_W])));

    p_beat_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (beats_q == CNT_W'(ROWS)));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_bus_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wb_cyc);

    p_busy_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req_valid && req_zero && !req_load)) |=> !busy);

    p_ram_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (wb_stb && wb_ack && (&ram_be) && (ram_wdata == '0) &&
                    (ram_row == wb_adr[OFF_W +: ROW_W])));

    p_stray_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_stb |-> !ram_we);

    p_alloc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> (!busy && vld_we && !vld_wdata));

    p_valid_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vld_we && vld_wdata));
endmodule

bind cline_zero cline_zero_chk #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES),
    .LINE_BYTES(LINE_BYTES)
) i_chk (.*);

// File: tb/test_cline_zero.sv
`timescale 1ns/1ps
// Bench for cline_zero: a behavioural model tracks the operation and
// every output is compared against it once per clock.
module test_cline_zero;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_zero, req_load, req_hit;
    logic [31:0] req_addr;
    logic [1:0]  req_hit_way, repl_way;
    logic        busy, done, wb_cyc, wb_stb, wb_we, wb_ack;
    logic [31:0] wb_adr;
    logic [7:0]  wb_sel, ram_be;
    logic [63:0] wb_dat_o, ram_wdata;
    logic        ram_we, tag_we, vld_we, vld_wdata;
    logic [3:0]  ram_set, tag_set, vld_set;
    logic [1:0]  ram_way, tag_way, vld_way;
    logic [2:0]  ram_row;
    logic [21:0] tag_wdata;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    string scen = "R1";

    // model state: 0 idle, 1 waiting for acks, 2 done pulse
    int          mstate = 0;
    int          mrow = 0, mbeats = 0;
    int unsigned mbase = 0;
    int          mset = 0, mway = 0;

    always #10 clk = ~clk;

    cline_zero i_cline_zero (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_zero(req_zero),
        .req_load(req_load), .req_addr(req_addr), .req_hit(req_hit),
        .req_hit_way(req_hit_way), .repl_way(repl_way), .busy(busy), .done(done),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_sel(wb_sel), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack), .ram_we(ram_we),
        .ram_set(ram_set), .ram_way(ram_way), .ram_row(ram_row), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .tag_we(tag_we), .tag_set(tag_set), .tag_way(tag_way),
        .tag_wdata(tag_wdata), .vld_we(vld_we), .vld_set(vld_set), .vld_way(vld_way),
        .vld_wdata(vld_wdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%0h expected=%0h t=%0t", tag, scen, act, exp, $time);
        end
    endtask

    // One clock: compare outputs against the model, then advance the model.
    task automatic step();
        bit acc, alloc, vwe;
        logic [31:0] eadr;
        #1;
        acc   = (mstate == 0) && req_valid && req_zero && !req_load;
        alloc = acc && !req_hit;
        eadr  = (mbase << 6) | (32'(mrow) << 3);
        chk("R1 busy", busy, mstate != 0);
        chk("R4 done", done, mstate == 2);
        chk("R2 cyc", wb_cyc, mstate == 1);
        chk("R2 stb", wb_stb, mstate == 1);
        chk("R2 we", wb_we, mstate == 1);
        chk("R2 sel", wb_sel, (mstate == 1) ? 8'hFF : 8'h00);
        chk("R2 dat", wb_dat_o, 0);
        chk("R3 adr", wb_adr, (mstate == 1) ? eadr : 32'h0);
        chk("R5 ram_we", ram_we, (mstate == 1) && wb_ack);
        if ((mstate == 1) && wb_ack) begin
            chk("R5 ram_row", ram_row, mrow);
            chk("R5 ram_set", ram_set, mset);
            chk("R6 ram_way", ram_way, mway);
            chk("R5 ram_be", ram_be, 8'hFF);
            chk("R5 ram_wdata", ram_wdata, 0);
        end
        chk("R7 tag_we", tag_we, alloc);
        if (alloc) begin
            chk("R7 tag_set", tag_set, (req_addr >> 6) & 15);
            chk("R7 tag_way", tag_way, repl_way);
            chk("R7 tag_wdata", tag_wdata, req_addr >> 10);
        end
        vwe = alloc || (mstate == 2);
        chk("R8 vld_we", vld_we, vwe);
        if (vwe) begin
            chk("R8 vld_wdata", vld_wdata, mstate == 2);
            chk("R8 vld_set", vld_set, (mstate == 2) ? mset : ((req_addr >> 6) & 15));
            chk("R8 vld_way", vld_way, (mstate == 2) ? mway : repl_way);
        end
        @(posedge clk);
        if (mstate == 2) begin
            mstate = 0;
        end else if (mstate == 1) begin
            if (wb_ack) begin
                mbeats++;
                mrow = (mrow + 1) % 8;
                if (mbeats == 8) mstate = 2;
            end
        end else if (acc) begin
            mstate = 1;
            mbeats = 0;
            mrow   = (req_addr >> 3) & 7;
            mbase  = req_addr >> 6;
            mset   = (req_addr >> 6) & 15;
            mway   = req_hit ? req_hit_way : repl_way;
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_zero = 0; req_load = 0; req_hit = 0;
        req_addr = 0; req_hit_way = 0; repl_way = 0; wb_ack = 0;
    endtask

    // One full zeroing operation; gap = idle cycles between acks,
    // poke = present a competing request while busy.
    task automatic do_op(input logic [31:0] addr, input bit hit, input logic [1:0] hway,
                         input logic [1:0] rway, input int gap, input bit poke);
        req_valid = 1; req_zero = 1; req_load = 0; req_addr = addr;
        req_hit = hit; req_hit_way = hway; repl_way = rway; wb_ack = 0;
        step();
        for (int k = 0; k < 200 && mstate != 0; k++) begin
            req_valid = poke;
            if (poke) begin
                req_addr = addr ^ 32'h5A5A_5A40;
                req_hit = ~hit; req_hit_way = ~hway; repl_way = ~rway;
            end
            wb_ack = (mstate == 1) && ((k % (gap + 1)) == gap);
            step();
        end
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        scen = "R1 reset";
        chk("R1 reset busy", busy, 0);
        chk("R2 reset cyc", wb_cyc, 0);
        rst_n = 1;
        step();

        scen = "R7 miss row0";
        do_op(32'h0000_1240, 0, 2'd0, 2'd2, 0, 0);
        step();

        scen = "R6 hit row5 gap1 R11 poke";
        do_op(32'h0000_ABE8, 1, 2'd1, 2'd3, 1, 1);
        step();

        scen = "R9 load flag";
        req_valid = 1; req_zero = 1; req_load = 1; req_addr = 32'h0000_2000;
        repeat (3) step();
        scen = "R9 zero flag low";
        req_load = 0; req_zero = 0;
        repeat (3) step();
        idle_inputs();

        scen = "R10 stray ack idle";
        wb_ack = 1;
        repeat (4) step();
        idle_inputs();

        scen = "R3 wrap row7 gap2";
        do_op(32'hFFFF_FFF8, 0, 2'd1, 2'd3, 2, 0);

        scen = "R4 back-to-back";
        do_op(32'h0000_0010, 1, 2'd2, 2'd0, 0, 1);
        do_op(32'h0000_0400, 0, 2'd0, 2'd1, 0, 0);
        step();

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule